// File: doc/BRIEF.md
# Auto-increment register pointer

This block steers byte accesses into the register file of a bus-controlled LED driver. Once the bus engine reports that a write transfer has matched one of the device addresses, the next byte it delivers is a control byte rather than data. The low five bits of that byte load the register pointer. The top three bits pick how the pointer moves after each data byte. The pointer can hold still, sweep the whole map, or loop over one of three sub-ranges. Each sub-range has its own end point and its own restart point.

Data bytes turn into write strobes at the current pointer. Registers that drive the outputs (indices 02h to 17h) are written into a shadow copy outside this block. A one-cycle commit pulse tells that copy to move into the live registers. The commit comes either after every such byte or once at the bus Stop, which lets several devices on one bus change their outputs together. Read bytes that the master has clocked out advance the pointer under the same rules as writes.

Received bytes arrive on a valid/ready stream. The block never applies back-pressure: `rx_ready` is held high, so a byte is taken in every cycle in which `rx_valid` is high. All other inputs are single-cycle event pulses or plain levels.

Top module: `regptr_autoinc`

## Requirements
- R1: After reset, `reg_idx` is 00h, `wr_en` and `commit` are low, and the option is 000.
- R2: The first accepted byte after `wr_xfer_start` is a control byte. Bits [4:0] load `reg_idx` and bits [7:5] load the option. This byte raises no `wr_en`.
- R3: With option 000, `reg_idx` stays unchanged after every data byte and every read.
- R4: With option 100, the pointer steps by one and goes from 1Bh to 00h.
- R5: With option 101, the pointer goes from 11h to 02h. At any other value it steps by one, with 1Bh going to 00h.
- R6: With option 110, the pointer goes from 13h to 12h. At any other value it steps by one, with 1Bh going to 00h.
- R7: With option 111, the pointer goes from 13h to 02h. At any other value it steps by one, with 1Bh going to 00h. Control byte F4h therefore yields 14h..1Bh, 00h..13h, 02h..13h, and so on.
- R8: Options 001, 010 and 011 keep the pointer where it is.
- R9: The pointer moves only on an accepted non-control byte or on a `rd_done` pulse. The new value shows on `reg_idx` one cycle later.
- R10: A data byte aimed at 1Dh, 1Eh or 1Fh is accepted (`rx_ready` is high) but raises no `wr_en`, and the pointer still advances.
- R11: `wr_en` carries `wr_addr` equal to the pointer and `wr_data` equal to the byte. `wr_live` is 0 for indices 02h..17h (shadowed) and 1 for all others.
- R12: With `update_on_ack` at 0, `commit` pulses once in the cycle after `bus_stop` if any shadowed byte was written since the last Stop, including a byte accepted in the same cycle as the Stop. Otherwise `commit` stays low.
- R13: With `update_on_ack` at 1, `commit` pulses in the cycle after each shadowed byte write.
- R14: `rx_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_xfer_start | input | 1 | Pulse: write transfer addressed to this device has begun |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Byte accepted (always high) |
| rx_data | input | 8 | Received byte |
| rd_done | input | 1 | Pulse: one byte was read out by the master |
| bus_stop | input | 1 | Pulse: Stop condition seen on the bus |
| update_on_ack | input | 1 | 1: commit after each byte, 0: commit at Stop |
| reg_idx | output | 5 | Current register pointer |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 5 | Register index for the write |
| wr_data | output | 8 | Write data |
| wr_live | output | 1 | 1: write goes to a live register, 0: to the shadow copy |
| commit | output | 1 | Pulse: move shadow copy to live registers |

## Verification
The two functions that can meet in one cycle are the staging of a shadowed data byte and the Stop that commits deferred writes. The bench drives a data byte for 04h with `bus_stop` in the same cycle, starting with nothing pending. It then checks that the byte's strobe appears, that exactly one commit follows in the next cycle, and that a later lone Stop adds no commit. A scoreboard predicts every strobe and commit from the option rules and compares them as they come out.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  localparam int PTR_W  = 5;
  localparam int DATA_W = 8;
  localparam int OPT_W  = 3;
  localparam int N_SCHEMES = 4;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [OPT_W-1:0]  opt_t;

  // last index of the writable map before natural wrap to zero
  localparam ptr_t LAST_MAPPED = ptr_t'(5'h1B);
  // first index that is read-only or unmapped
  localparam ptr_t FIRST_RO    = ptr_t'(5'h1D);
  // range of output-affecting registers that are shadowed
  localparam ptr_t STAGE_LO    = ptr_t'(5'h02);
  localparam ptr_t STAGE_HI    = ptr_t'(5'h17);

  // per scheme (selected by option bits [1:0] when bit 2 set): end and restart
  localparam ptr_t WRAP_END [N_SCHEMES] = '{ptr_t'(5'h1B), ptr_t'(5'h11), ptr_t'(5'h13), ptr_t'(5'h13)};
  localparam ptr_t WRAP_TO  [N_SCHEMES] = '{ptr_t'(5'h00), ptr_t'(5'h02), ptr_t'(5'h12), ptr_t'(5'h02)};
endpackage

// File: rtl/regptr_next.sv
module regptr_next
  import regptr_pkg::*;
(
  input  ptr_t cur,
  input  opt_t opt,
  output ptr_t nxt
);
  ptr_t cand [N_SCHEMES];

  // one candidate per wrap scheme
  for (genvar g = 0; g < N_SCHEMES; g++) begin : g_scheme
    assign cand[g] = (cur == WRAP_END[g]) ? WRAP_TO[g] :
                     (cur == LAST_MAPPED) ? '0 :
                     cur + ptr_t'(1);
  end

  // option bit 2 clear: no increment (000) or reserved (001..011) -> hold
  always_comb begin
    if (opt[OPT_W-1]) nxt = cand[opt[1:0]];
    else              nxt = cur;
  end
endmodule

// File: rtl/regptr_wrgate.sv
module regptr_wrgate
  import regptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data_fire,
  input  ptr_t ptr,
  output logic wr_en,
  output logic wr_live,
  output logic staged_wr
);
  logic writable;
  logic in_stage;

  always_comb begin
    writable  = (ptr < FIRST_RO);
    in_stage  = (ptr >= STAGE_LO) && (ptr <= STAGE_HI);
    wr_en     = data_fire && writable;
    wr_live   = !in_stage;
    staged_wr = wr_en && in_stage;
  end

  // R10: no strobe ever lands on the read-only / unmapped tail
  assert_ro_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr <= ptr_t'(5'h1C)));

  // R11: a shadowed write is never flagged live
  assert_live_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    staged_wr |-> !wr_live);
endmodule

// File: rtl/regptr_commit.sv
module regptr_commit
  import regptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic on_ack,
  input  logic staged_wr,
  input  logic stop,
  output logic commit
);
  logic pend_q;
  logic commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      commit_q <= 1'b0;
    end else if (on_ack) begin
      commit_q <= staged_wr;
      pend_q   <= 1'b0;
    end else if (stop) begin
      commit_q <= pend_q || staged_wr;
      pend_q   <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (staged_wr) pend_q <= 1'b1;
    end
  end

  assign commit = commit_q;

  // R13: per-byte commit follows every shadowed write
  assert_ack_commit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (on_ack && staged_wr) |=> commit);

  // R12: deferred mode never commits without a Stop
  assert_defer_nostop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_ack && !stop) |=> !commit);

  // R12: Stop with nothing staged yields no commit
  assert_defer_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_ack && stop && !pend_q && !staged_wr) |=> !commit);
endmodule

// File: rtl/regptr_autoinc.sv
module regptr_autoinc
  import regptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_xfer_start,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_done,
  input  logic              bus_stop,
  input  logic              update_on_ack,
  output logic [PTR_W-1:0]  reg_idx,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_live,
  output logic              commit
);
  ptr_t ptr_q;
  opt_t opt_q;
  logic expect_ctrl_q;
  ptr_t ptr_nxt;
  logic ctrl_byte;
  logic data_fire;
  logic adv;
  logic staged_wr;

  assign rx_ready  = 1'b1;
  assign ctrl_byte = rx_valid && expect_ctrl_q;
  assign data_fire = rx_valid && !expect_ctrl_q;
  assign adv       = data_fire || (rd_done && !rx_valid);

  regptr_next u_next (
    .cur (ptr_q),
    .opt (opt_q),
    .nxt (ptr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q         <= '0;
      opt_q         <= '0;
      expect_ctrl_q <= 1'b0;
    end else begin
      if (wr_xfer_start)            expect_ctrl_q <= 1'b1;
      else if (ctrl_byte || bus_stop) expect_ctrl_q <= 1'b0;

      if (ctrl_byte) begin
        ptr_q <= rx_data[PTR_W-1:0];
        opt_q <= rx_data[DATA_W-1:DATA_W-OPT_W];
      end else if (adv) begin
        ptr_q <= ptr_nxt;
      end
    end
  end

  regptr_wrgate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_fire (data_fire),
    .ptr       (ptr_q),
    .wr_en     (wr_en),
    .wr_live   (wr_live),
    .staged_wr (staged_wr)
  );

  regptr_commit u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_ack    (update_on_ack),
    .staged_wr (staged_wr),
    .stop      (bus_stop),
    .commit    (commit)
  );

  assign reg_idx = ptr_q;
  assign wr_addr = ptr_q;
  assign wr_data = rx_data;

  // R2: the control byte itself is never written
  assert_ctrl_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_byte |-> !wr_en);

  // R3 / R8: option without bit 2 holds the pointer
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !opt_q[OPT_W-1]) |=> $stable(reg_idx));

  // R4: full sweep wraps from the last mapped register to zero
  assert_wrap_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && opt_q == 3'b100 && ptr_q == ptr_t'(5'h1B)) |=> (reg_idx == '0));

  // R7: combined range restarts at the first duty register
  assert_wrap_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && opt_q == 3'b111 && ptr_q == ptr_t'(5'h13)) |=> (reg_idx == ptr_t'(5'h02)));

  // R9: no byte and no read, no movement
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !rd_done) |=> $stable(reg_idx));
endmodule

// File: tb/sim_regptr_autoinc.sv
module sim_regptr_autoinc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_xfer_start = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = '0;
  logic       rd_done = 1'b0;
  logic       bus_stop = 1'b0;
  logic       update_on_ack = 1'b0;
  logic [4:0] reg_idx;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic       wr_live;
  logic       commit;

  always #10 clk = ~clk;

  regptr_autoinc u0 (
    .clk(clk), .rst_n(rst_n), .wr_xfer_start(wr_xfer_start),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rd_done(rd_done), .bus_stop(bus_stop), .update_on_ack(update_on_ack),
    .reg_idx(reg_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_live(wr_live), .commit(commit)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [13:0] exp_q [$];
  int exp_commit = 0;
  int act_commit = 0;
  logic [4:0] m_ptr = '0;
  logic [2:0] m_opt = '0;
  bit m_expect = 0;
  bit m_pend = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] step(logic [4:0] p);
    return (p == 5'h1B) ? 5'h00 : p + 5'd1;
  endfunction

  // pointer rules taken from R3..R8
  function automatic logic [4:0] model_next(logic [4:0] p, logic [2:0] o);
    case (o)
      3'b100:  return step(p);
      3'b101:  return (p == 5'h11) ? 5'h02 : step(p);
      3'b110:  return (p == 5'h13) ? 5'h12 : step(p);
      3'b111:  return (p == 5'h13) ? 5'h02 : step(p);
      default: return p;
    endcase
  endfunction

  // monitor: pops predicted strobes, counts commits
  always @(negedge clk) begin
    #8;
    if (rst_n) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected write", int'(wr_addr), 0);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data, wr_live} == e, "R11 write addr/data/live",
              int'({wr_addr, wr_data, wr_live}), int'(e));
        end
      end
      if (commit) act_commit++;
    end
  end

  task automatic start_wr();
    @(negedge clk);
    wr_xfer_start = 1'b1;
    m_expect = 1;
    @(negedge clk);
    wr_xfer_start = 1'b0;
  endtask

  task automatic send(logic [7:0] d, string tag, bit with_stop = 0);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    bus_stop = with_stop;
    if (m_expect) begin
      m_ptr = d[4:0];
      m_opt = d[7:5];
      m_expect = 0;
    end else begin
      if (m_ptr < 5'h1D) begin
        bit live;
        live = !(m_ptr >= 5'h02 && m_ptr <= 5'h17);
        exp_q.push_back({m_ptr, d, live});
        if (!live) begin
          if (update_on_ack) exp_commit++;
          else m_pend = 1;
        end
      end
      m_ptr = model_next(m_ptr, m_opt);
    end
    if (with_stop) begin
      if (!update_on_ack && m_pend) exp_commit++;
      m_pend = 0;
      m_expect = 0;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    bus_stop = 1'b0;
    #8;
    chk(reg_idx == m_ptr, tag, int'(reg_idx), int'(m_ptr));
  endtask

  task automatic stop_only();
    @(negedge clk);
    bus_stop = 1'b1;
    if (!update_on_ack && m_pend) exp_commit++;
    m_pend = 0;
    m_expect = 0;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic rd(string tag);
    @(negedge clk);
    rd_done = 1'b1;
    m_ptr = model_next(m_ptr, m_opt);
    @(negedge clk);
    rd_done = 1'b0;
    #8;
    chk(reg_idx == m_ptr, tag, int'(reg_idx), int'(m_ptr));
  endtask

  task automatic settle(string tag);
    repeat (3) @(negedge clk);
    #9;
    chk(act_commit == exp_commit, tag, act_commit, exp_commit);
    chk(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #8;
    chk(reg_idx == 5'h00 && !wr_en && !commit, "R1 reset state",
        int'({reg_idx, wr_en, commit}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #8;
    chk(rx_ready == 1'b1, "R14 ready high", int'(rx_ready), 1);

    // R1: idle read with option 000 after reset holds pointer
    rd("R1 option 000 after reset");

    // R7 + R2: sequence from control byte F4h
    start_wr();
    send(8'hF4, "R2 control byte loads pointer");
    for (int i = 0; i < 30; i++) send(8'h40 + 8'(i), "R7 option 111 sequence");
    stop_only();
    settle("R12 commit after long write");

    // R3: option 000 keeps hitting one register
    start_wr();
    send(8'h05, "R2 control 05h");
    for (int i = 0; i < 3; i++) send(8'hA0 + 8'(i), "R3 no increment");
    stop_only();
    settle("R3 commits");

    // R5: duty range loop
    start_wr();
    send(8'hB0, "R2 control B0h");
    for (int i = 0; i < 4; i++) send(8'h11 + 8'(i), "R5 duty loop");
    stop_only();
    settle("R5 commits");

    // R6: group range loop
    start_wr();
    send(8'hD2, "R2 control D2h");
    for (int i = 0; i < 4; i++) send(8'h22 + 8'(i), "R6 group loop");
    stop_only();
    settle("R6 commits");

    // R4: full sweep across the top
    start_wr();
    send(8'h9A, "R2 control 9Ah");
    for (int i = 0; i < 4; i++) send(8'h33 + 8'(i), "R4 full sweep wrap");
    stop_only();
    settle("R4 commits");

    // R8: reserved option holds
    start_wr();
    send(8'h27, "R2 control 27h");
    for (int i = 0; i < 3; i++) send(8'h55 + 8'(i), "R8 reserved hold");
    stop_only();
    settle("R8 commits");

    // R10: read-only tail discarded, pointer still moves
    start_wr();
    send(8'h9D, "R2 control 9Dh");
    for (int i = 0; i < 4; i++) send(8'h66 + 8'(i), "R10 read-only skip");
    chk(rx_ready == 1'b1, "R10 byte accepted", int'(rx_ready), 1);
    stop_only();
    settle("R10 no stray strobes");

    // R9: reads advance under the chosen option
    start_wr();
    send(8'hB0, "R2 control for read");
    stop_only();
    for (int i = 0; i < 3; i++) rd("R9 read advances pointer");
    settle("R9 reads commit nothing");

    // R12: deferred, nothing before Stop
    update_on_ack = 1'b0;
    start_wr();
    send(8'h82, "R2 control 82h");
    send(8'h71, "R12 staged write");
    send(8'h72, "R12 staged write");
    repeat (2) @(negedge clk);
    #8;
    chk(act_commit == exp_commit, "R12 no commit before Stop", act_commit, exp_commit);
    stop_only();
    settle("R12 single commit at Stop");

    // R12: Stop in the same cycle as a staged byte
    start_wr();
    send(8'h84, "R2 control 84h");
    send(8'h7A, "R12 write with Stop", 1);
    settle("R12 same-cycle Stop commit");
    stop_only();
    settle("R12 lone Stop no commit");

    // R13: commit per byte; live register gives none
    update_on_ack = 1'b1;
    start_wr();
    send(8'h80, "R2 control 80h");
    for (int i = 0; i < 4; i++) send(8'h90 + 8'(i), "R13 per-ack writes");
    stop_only();
    settle("R13 commit per shadowed byte");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule